// File: doc/BRIEF.md
# SCSI Initiator Programmed-Transfer Handshake Engine

This block carries a counted run of bytes across an asynchronous SCSI bus on behalf of the initiator, one REQ/ACK handshake per byte. Software, or a sequencer, names the information-transfer phase it expects and how many bytes to move, then pulses `start`. Outbound bytes are pulled from a valid/ready stream (`tx_*`), and inbound bytes are pushed into a second valid/ready stream (`rx_*`). The engine watches the target's REQ and the three phase lines through a synchronizer. It drives ACK, ATN and the data lines itself.

Each byte waits for REQ. The engine then checks that the phase on the bus is still the expected one before it touches the byte. If the phase has changed, the run stops early and the remaining count is reported. During MESSAGE OUT, ATN is held while further message bytes remain, and it is withdrawn on the final byte before ACK goes high. When the run ends, the engine lets the bus settle for a fixed window. It then reports the residual count, the phase on the bus (or "unknown" when REQ is low), and a pass/fail flag.

Stream rules: `tx_ready` is high only while the engine waits for the byte that belongs to a REQ it has already seen and found valid. A byte is taken on a cycle where `tx_valid` and `tx_ready` are both high. `rx_valid` is raised with a byte latched from the bus and stays high, with `rx_data` unchanged, until `rx_ready` is seen. ACK for that byte is withheld until then, so back-pressure on `rx` stalls the bus handshake.

Top module: `scsi_pio_engine`

## Requirements
- R1: After reset, `bus_ack`, `bus_atn`, `bus_data_oe`, `busy`, `tx_ready`, `rx_valid` and `done` are all low.
- R2: The phase code is {MSG, C/D, I/O} with I/O in bit 0 (1 = target to initiator). The engine drives ACK and the data lines only while the synchronized bus phase equals the expected phase. On a REQ whose phase differs, the engine raises no ACK, moves no stream byte, and ends with `ok`=0, `residual` equal to the bytes not yet moved, `end_phase` equal to the bus phase and `end_unknown`=0.
- R3: For an outbound phase (I/O=0), after a valid REQ the engine takes one byte from `tx`, drives it with `bus_data_oe` high, and holds it for at least SETUP_CLKS cycles before ACK rises. `tx_ready` is never high while ACK or the data drive is active.
- R4: For an inbound phase (I/O=1), the engine latches `bus_data_in` when it sees REQ and offers the byte on `rx`. ACK rises only after that byte was accepted, and `rx_data` holds steady while `rx_valid` is high and `rx_ready` is low.
- R5: ACK stays high until REQ is seen low. ACK and the data drive are then released together, and the next byte waits for a fresh REQ.
- R6: In MESSAGE OUT (3'b110), ATN goes high at start (count non-zero) and stays high while more than one byte remains, including between bytes after ACK is released.
- R7: On the last MESSAGE OUT byte, ATN is low from the moment the byte is driven, before ACK rises, and ATN is low after the run ends.
- R8: After the run ends, the engine waits END_WAIT cycles and then reports the bus phase with `end_unknown`=0 if REQ is high, or `end_unknown`=1 if REQ is low.
- R9: `ok` is 1 when the residual is zero or when REQ is high with the expected phase, and 0 otherwise. `done` is a one-cycle pulse, and the result outputs hold until the next run.
- R10: A start with a byte count of zero moves no byte, raises no ACK, and ends with `done`, `ok`=1 and `residual`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (taken when idle) |
| exp_phase | input | 3 | Expected phase {MSG, C/D, I/O} |
| byte_count | input | CNT_W | Bytes to move |
| tx_valid | input | 1 | Outbound byte available |
| tx_ready | output | 1 | Engine takes outbound byte |
| tx_data | input | 8 | Outbound byte |
| rx_valid | output | 1 | Inbound byte available |
| rx_ready | input | 1 | Consumer takes inbound byte |
| rx_data | output | 8 | Inbound byte |
| bus_req | input | 1 | Target REQ (asynchronous) |
| bus_phase | input | 3 | Target phase lines {MSG, C/D, I/O} (asynchronous) |
| bus_data_in | input | 8 | Data lines as seen on the bus |
| bus_ack | output | 1 | Initiator ACK |
| bus_atn | output | 1 | Initiator ATN |
| bus_data_out | output | 8 | Data driven to the bus |
| bus_data_oe | output | 1 | Enable for `bus_data_out` |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| ok | output | 1 | Run succeeded |
| residual | output | CNT_W | Bytes not moved |
| end_phase | output | 3 | Phase seen at end (0 when unknown) |
| end_unknown | output | 1 | REQ was low at end |

## Verification
The bench plays the target and checks the engine's pins on every clock. It targets several corner cases:
- A phase change that arrives with REQ mid-run. A design that skipped the per-byte compare would ACK a status byte as data and report a wrong residual.
- The final MESSAGE OUT byte, where a design that updated ATN late would still show ATN when ACK rises, and the gap between message bytes, where a design that cleared ATN with ACK would drop it too early.
- Back-pressure on the inbound stream, which exposes a design that raises ACK before the byte is accepted, so the target moves on and the byte is lost.
- Ends with and without REQ, and a zero-count start, which catch wrong end-phase reporting and spurious handshakes.

// File: rtl/scsi_pio_pkg.sv
`timescale 1ns/1ps
package scsi_pio_pkg;

  localparam logic [2:0] PH_MSG_OUT = 3'b110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_REQ,
    ST_TX_GET,
    ST_RX_PUT,
    ST_SETUP,
    ST_ACK,
    ST_SETTLE
  } xfer_state_t;

  function automatic logic phase_inbound(input logic [2:0] ph);
    return ph[0];
  endfunction

endpackage

// File: rtl/scsi_bus_sync.sv
`timescale 1ns/1ps
module scsi_bus_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= '0;
          else        chain[0] <= async_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/scsi_wait_timer.sv
`timescale 1ns/1ps
module scsi_wait_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= '0;
    else if (load)           remain <= load_val;
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign expired = (remain == '0);
endmodule

// File: rtl/scsi_xfer_ctrl.sv
`timescale 1ns/1ps
module scsi_xfer_ctrl
  import scsi_pio_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int SETUP_CLKS = 3,
  parameter int END_WAIT   = 8,
  parameter int TW         = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       exp_phase,
  input  logic [CNT_W-1:0] byte_count,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [7:0]       tx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [7:0]       rx_data,
  input  logic             req_s,
  input  logic [2:0]       phase_s,
  input  logic [7:0]       bus_data_in,
  output logic             tmr_load,
  output logic [TW-1:0]    tmr_val,
  input  logic             tmr_expired,
  output logic             ack_q,
  output logic             atn_q,
  output logic             drive_q,
  output logic [7:0]       dout_q,
  output logic [2:0]       exp_q,
  output logic             busy,
  output logic             done,
  output logic             ok,
  output logic [CNT_W-1:0] residual,
  output logic [2:0]       end_phase,
  output logic             end_unknown
);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [TW-1:0]    SETUP_TV = TW'(SETUP_CLKS);
  localparam logic [TW-1:0]    END_TV   = TW'(END_WAIT);

  xfer_state_t      state;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       rx_buf;
  logic             phase_ok;
  logic             is_msgout;

  assign phase_ok  = (phase_s == exp_q);
  assign is_msgout = (exp_q == PH_MSG_OUT);
  assign tx_ready  = (state == ST_TX_GET);
  assign rx_valid  = (state == ST_RX_PUT);
  assign rx_data   = rx_buf;
  assign busy      = (state != ST_IDLE);

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = END_TV;
    unique case (state)
      ST_IDLE:     tmr_load = start;
      ST_WAIT_REQ: tmr_load = req_s && !phase_ok;
      ST_TX_GET: begin
        tmr_load = tx_valid;
        tmr_val  = SETUP_TV;
      end
      ST_ACK:      tmr_load = !req_s && (cnt == CNT_ONE);
      default:     tmr_load = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      rx_buf      <= '0;
      ack_q       <= 1'b0;
      atn_q       <= 1'b0;
      drive_q     <= 1'b0;
      dout_q      <= '0;
      exp_q       <= '0;
      done        <= 1'b0;
      ok          <= 1'b0;
      residual    <= '0;
      end_phase   <= '0;
      end_unknown <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          exp_q <= exp_phase;
          cnt   <= byte_count;
          atn_q <= (exp_phase == PH_MSG_OUT) && (byte_count != '0);
          state <= (byte_count == '0) ? ST_SETTLE : ST_WAIT_REQ;
        end
        ST_WAIT_REQ: if (req_s) begin
          if (!phase_ok) begin
            state <= ST_SETTLE;
          end else if (phase_inbound(exp_q)) begin
            rx_buf <= bus_data_in;
            state  <= ST_RX_PUT;
          end else begin
            state <= ST_TX_GET;
          end
        end
        ST_TX_GET: if (tx_valid) begin
          dout_q  <= tx_data;
          drive_q <= 1'b1;
          if (is_msgout) atn_q <= (cnt > CNT_ONE);
          state   <= ST_SETUP;
        end
        ST_SETUP: if (tmr_expired) begin
          ack_q <= 1'b1;
          state <= ST_ACK;
        end
        ST_RX_PUT: if (rx_ready) begin
          ack_q <= 1'b1;
          state <= ST_ACK;
        end
        ST_ACK: if (!req_s) begin
          ack_q   <= 1'b0;
          drive_q <= 1'b0;
          cnt     <= cnt - 1'b1;
          state   <= (cnt == CNT_ONE) ? ST_SETTLE : ST_WAIT_REQ;
        end
        ST_SETTLE: if (tmr_expired) begin
          done        <= 1'b1;
          residual    <= cnt;
          end_unknown <= !req_s;
          end_phase   <= req_s ? phase_s : 3'b000;
          ok          <= (cnt == '0) || (req_s && phase_ok);
          atn_q       <= 1'b0;
          state       <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: a REQ in a foreign phase never leads to a handshake
  assert_no_ack_on_mismatch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT_REQ && req_s && !phase_ok) |=> (!ack_q && !drive_q));

  // R3: outbound ACK only follows a byte already on the lines
  assert_ack_after_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ack_q) && !phase_inbound(exp_q)) |-> $past(drive_q));

  // R3: stream byte requested only while no handshake is active
  assert_tx_idle_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (!ack_q && !drive_q));

  // R4: inbound byte held under back-pressure
  assert_rx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R5: ACK kept while REQ is still seen high
  assert_ack_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q && req_s) |=> ack_q);

  // R7: final message byte handshakes without ATN
  assert_atn_low_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q && is_msgout && cnt == CNT_ONE) |-> !atn_q);

  // R9: completion flag lasts one cycle
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/scsi_pio_engine.sv
`timescale 1ns/1ps
module scsi_pio_engine #(
  parameter int CNT_W       = 8,
  parameter int SETUP_CLKS  = 3,
  parameter int END_WAIT    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       exp_phase,
  input  logic [CNT_W-1:0] byte_count,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [7:0]       tx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [7:0]       rx_data,
  input  logic             bus_req,
  input  logic [2:0]       bus_phase,
  input  logic [7:0]       bus_data_in,
  output logic             bus_ack,
  output logic             bus_atn,
  output logic [7:0]       bus_data_out,
  output logic             bus_data_oe,
  output logic             busy,
  output logic             done,
  output logic             ok,
  output logic [CNT_W-1:0] residual,
  output logic [2:0]       end_phase,
  output logic             end_unknown
);
  localparam int MAX_WAIT = (SETUP_CLKS > END_WAIT) ? SETUP_CLKS : END_WAIT;
  localparam int TW       = $clog2(MAX_WAIT + 1) + 1;

  logic [3:0]    sync_q;
  logic          req_s;
  logic [2:0]    phase_s;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_expired;
  logic          ack_q;
  logic          drive_q;
  logic [2:0]    exp_q;
  logic          match;

  scsi_bus_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({bus_req, bus_phase}),
    .sync_out (sync_q)
  );
  assign req_s   = sync_q[3];
  assign phase_s = sync_q[2:0];

  scsi_wait_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  scsi_xfer_ctrl #(
    .CNT_W(CNT_W), .SETUP_CLKS(SETUP_CLKS), .END_WAIT(END_WAIT), .TW(TW)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .exp_phase   (exp_phase),
    .byte_count  (byte_count),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .tx_data     (tx_data),
    .rx_valid    (rx_valid),
    .rx_ready    (rx_ready),
    .rx_data     (rx_data),
    .req_s       (req_s),
    .phase_s     (phase_s),
    .bus_data_in (bus_data_in),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .tmr_expired (tmr_expired),
    .ack_q       (ack_q),
    .atn_q       (bus_atn),
    .drive_q     (drive_q),
    .dout_q      (bus_data_out),
    .exp_q       (exp_q),
    .busy        (busy),
    .done        (done),
    .ok          (ok),
    .residual    (residual),
    .end_phase   (end_phase),
    .end_unknown (end_unknown)
  );

  assign match       = (phase_s == exp_q);
  assign bus_ack     = ack_q & match;
  assign bus_data_oe = drive_q & match & ~exp_q[0];

  // R3: the data drive is only ever used for initiator-to-target phases
  assert_oe_outbound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_data_oe |-> !phase_s[0]);
endmodule

// File: tb/scsi_pio_engine_tb_top.sv
`timescale 1ns/1ps
module scsi_pio_engine_tb_top;
  localparam int CNT_W = 8;
  localparam int SETUP = 3;
  localparam int ENDW  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic start = 0; logic [2:0] exp_phase = 0; logic [CNT_W-1:0] byte_count = 0;
  logic tx_valid = 0, tx_ready; logic [7:0] tx_data = 0;
  logic rx_valid, rx_ready = 1; logic [7:0] rx_data;
  logic bus_req = 0; logic [2:0] bus_phase = 0; logic [7:0] bus_data_in = 0;
  logic bus_ack, bus_atn, bus_data_oe, busy, done, ok, end_unknown;
  logic [7:0] bus_data_out; logic [CNT_W-1:0] residual; logic [2:0] end_phase;

  scsi_pio_engine #(.CNT_W(CNT_W), .SETUP_CLKS(SETUP), .END_WAIT(ENDW), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .exp_phase(exp_phase), .byte_count(byte_count),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .bus_req(bus_req), .bus_phase(bus_phase), .bus_data_in(bus_data_in),
    .bus_ack(bus_ack), .bus_atn(bus_atn), .bus_data_out(bus_data_out), .bus_data_oe(bus_data_oe),
    .busy(busy), .done(done), .ok(ok), .residual(residual), .end_phase(end_phase),
    .end_unknown(end_unknown));

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0] tx_q[$]; logic [7:0] rx_got[$];
  bit tx_fire = 0, tx_gap = 0, rx_stall = 0;
  bit ack_allowed = 0, oe_allowed = 0, atn_chk = 0, atn_exp = 0;
  logic [7:0] mon_byte = 0;

  task automatic chk(input string req, input bit cond, input int act, input int expv);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, expv, $time);
    end
  endtask

  // stream side: sampled at negedge, driven just after posedge
  always @(negedge clk) begin
    cyc++;
    tx_fire = tx_valid && tx_ready;
    if (rx_valid && rx_ready) rx_got.push_back(rx_data);
  end
  always @(posedge clk) begin
    #1;
    if (tx_fire) begin void'(tx_q.pop_front()); end
    tx_valid = (tx_q.size() > 0) && !(tx_gap && tx_fire);
    tx_data  = (tx_q.size() > 0) ? tx_q[0] : 8'h00;
    rx_ready = rx_stall ? (cyc % 3 == 0) : 1'b1;
    tx_fire = 0;
  end

  // per-clock reference checks against the target's view of the bus
  always @(negedge clk) if (rst_n) begin
    if (bus_ack) chk("R2/R5 ack only on a live matching REQ", ack_allowed, bus_ack, 0);
    if (bus_data_oe) begin
      chk("R2 data drive allowed", oe_allowed, bus_data_oe, 0);
      chk("R3 driven byte", bus_data_out == mon_byte, bus_data_out, mon_byte);
    end
    if (atn_chk) chk("R6 ATN level", bus_atn == atn_exp, bus_atn, atn_exp);
  end

  task automatic clk_n(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic run_start(input logic [2:0] ph, input int n);
    clk_n(1); exp_phase = ph; byte_count = CNT_W'(n); start = 1;
    clk_n(1); start = 0;
  endtask

  // target side of one byte; last_msg marks the final MESSAGE OUT byte
  task automatic tgt_byte(input logic [2:0] ph, input logic [7:0] din, input logic [7:0] dexp,
                          input bit last_msg);
    int setup_cyc = 0;
    int rx_before = rx_got.size();
    clk_n(1); bus_phase = ph; bus_data_in = din;
    clk_n(1);
    if (last_msg) atn_chk = 0;
    mon_byte = dexp; oe_allowed = !ph[0]; ack_allowed = 1; bus_req = 1;
    do begin
      @(negedge clk);
      if (bus_data_oe && !bus_ack) setup_cyc++;
      if (last_msg && bus_data_oe)
        chk("R7 ATN low before ACK on last message byte", bus_atn == 0, bus_atn, 0);
    end while (!bus_ack);
    if (!ph[0]) chk("R3 setup cycles before ACK", setup_cyc >= SETUP, setup_cyc, SETUP);
    else begin
      chk("R4 byte accepted before ACK", rx_got.size() == rx_before + 1, rx_got.size(), rx_before + 1);
      if (rx_got.size() > 0) chk("R4 inbound byte", rx_got[$] == din, rx_got[$], din);
    end
    clk_n(2);
    chk("R5 ACK held while REQ high", bus_ack == 1, bus_ack, 1);
    bus_req = 0;
    do @(negedge clk); while (bus_ack);
    chk("R5 data released with ACK", bus_data_oe == 0, bus_data_oe, 0);
    ack_allowed = 0; oe_allowed = 0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  task automatic check_end(input string req, input bit e_ok, input int e_res,
                           input logic [2:0] e_ph, input bit e_unk);
    chk({req, " ok"}, ok == e_ok, ok, e_ok);
    chk({req, " residual"}, residual == e_res, residual, e_res);
    chk({req, " end_unknown"}, end_unknown == e_unk, end_unknown, e_unk);
    chk({req, " end_phase"}, end_phase == e_ph, end_phase, e_ph);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    clk_n(3);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ack", bus_ack == 0, bus_ack, 0);
    chk("R1 atn", bus_atn == 0, bus_atn, 0);
    chk("R1 oe", bus_data_oe == 0, bus_data_oe, 0);
    chk("R1 busy/done", (busy | done) == 0, busy, 0);
    chk("R1 streams", (tx_ready | rx_valid) == 0, tx_ready, 0);

    // data out, four bytes, source with gaps, ends with REQ low
    tx_gap = 1;
    tx_q = '{8'hA5, 8'h3C, 8'h00, 8'hFF};
    run_start(3'b000, 4);
    foreach (tx_q[i]) ; // queue drains as bytes are taken
    tgt_byte(3'b000, 8'h00, 8'hA5, 0);
    tgt_byte(3'b000, 8'h00, 8'h3C, 0);
    tgt_byte(3'b000, 8'h00, 8'h00, 0);
    tgt_byte(3'b000, 8'h00, 8'hFF, 0);
    wait_done();
    check_end("R8/R9 data out, REQ low at end", 1, 0, 3'b000, 1);
    @(negedge clk);
    chk("R9 done is a pulse", done == 0, done, 0);
    chk("R9 result held", residual == 0 && end_unknown == 1, end_unknown, 1);
    tx_gap = 0;

    // MESSAGE OUT, three bytes, then target goes to COMMAND with REQ
    tx_q = '{8'h80, 8'h20, 8'h07};
    run_start(3'b110, 3);
    @(negedge clk);
    chk("R6 ATN at start", bus_atn == 1, bus_atn, 1);
    atn_exp = 1; atn_chk = 1;
    tgt_byte(3'b110, 8'h00, 8'h80, 0);
    tgt_byte(3'b110, 8'h00, 8'h20, 0);
    clk_n(2);
    chk("R6 ATN held between message bytes", bus_atn == 1, bus_atn, 1);
    tgt_byte(3'b110, 8'h00, 8'h07, 1);
    bus_phase = 3'b010;
    clk_n(1); bus_req = 1;
    wait_done();
    check_end("R8/R9 message out, REQ high at end", 1, 0, 3'b010, 0);
    chk("R7 ATN low after run", bus_atn == 0, bus_atn, 0);
    clk_n(1); bus_req = 0;
    clk_n(4);

    // single-byte MESSAGE OUT
    tx_q = '{8'hC0};
    run_start(3'b110, 1);
    @(negedge clk);
    chk("R6 ATN raised for lone message byte", bus_atn == 1, bus_atn, 1);
    tgt_byte(3'b110, 8'h00, 8'hC0, 1);
    wait_done();
    check_end("R9 single message byte", 1, 0, 3'b000, 1);

    // data in with consumer back-pressure
    rx_got.delete();
    rx_stall = 1;
    run_start(3'b001, 3);
    tgt_byte(3'b001, 8'h5A, 8'h00, 0);
    tgt_byte(3'b001, 8'hC3, 8'h00, 0);
    tgt_byte(3'b001, 8'h11, 8'h00, 0);
    wait_done();
    check_end("R4/R9 data in", 1, 0, 3'b000, 1);
    chk("R4 bytes received", rx_got.size() == 3, rx_got.size(), 3);
    rx_stall = 0;

    // data in, target switches to STATUS after two bytes
    rx_got.delete();
    run_start(3'b001, 4);
    tgt_byte(3'b001, 8'h01, 8'h00, 0);
    tgt_byte(3'b001, 8'h02, 8'h00, 0);
    clk_n(1); bus_phase = 3'b011; bus_data_in = 8'hEE;
    clk_n(1); bus_req = 1;
    wait_done();
    check_end("R2/R9 mismatch mid-run", 0, 2, 3'b011, 0);
    chk("R2 no byte taken on foreign phase", rx_got.size() == 2, rx_got.size(), 2);
    clk_n(1); bus_req = 0;
    clk_n(4);

    // data out, first REQ already in a foreign phase
    tx_q = '{8'h99};
    run_start(3'b000, 2);
    clk_n(1); bus_phase = 3'b111;
    clk_n(1); bus_req = 1;
    wait_done();
    check_end("R2/R9 mismatch on first byte", 0, 2, 3'b111, 0);
    chk("R2 outbound byte not consumed", tx_q.size() == 1, tx_q.size(), 1);
    clk_n(1); bus_req = 0; tx_q.delete();
    clk_n(4);

    // zero count
    run_start(3'b000, 0);
    wait_done();
    check_end("R10 zero count", 1, 0, 3'b000, 1);
    chk("R10 no ATN", bus_atn == 0, bus_atn, 0);

    clk_n(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule